// File: doc/BRIEF.md
# Two-Copy Control Endpoint Receive Status Register

This block holds the receive status that firmware reads for a bidirectional USB control endpoint. The packet engine signals the end of every received packet with a one-cycle event. The event carries the SETUP flag, the data toggle seen on the wire, a last-packet flag and the current receive FIFO fill level. Firmware reads an 8-bit status word, and a one-cycle read strobe tells the block that the word has been consumed.

Two status copies are kept. A zero-length OUT or SETUP packet may be followed at once by a SETUP packet that carries data. In that case both statuses are held and come out in arrival order on two consecutive reads. The flag bits clear when the word is read. The byte count tracks the live FIFO level, except while an older copy waits in front of a newer one: the older copy then shows the count it latched when it arrived.

The controller is a three-state machine: `ST_EMPTY` (no copy held), `ST_ONE` (front copy held) and `ST_TWO` (front and back copies held). The transitions are as follows:
- Event: `ST_EMPTY`→`ST_ONE` and `ST_ONE`→`ST_TWO`.
- Read: `ST_ONE`→`ST_EMPTY` and `ST_TWO`→`ST_ONE`.
- Read and event in the same cycle: the state holds at `ST_ONE` or `ST_TWO`.
- Event in `ST_TWO` with no read: the state holds at `ST_TWO`. This is the overwrite/overflow transition.

Top module: `rx_stat_dbuf`

## Requirements
- R1: The status word is laid out as follows: bit 7 always reads 0, bit 6 is the SETUP flag, bit 5 is the received toggle, bit 4 is the last-packet flag, and bits 3..0 are the byte count.
- R2: With one or no copy held, the byte count equals the live FIFO level, saturated at 8.
- R3: A read strobe in `ST_ONE` with no event clears the SETUP, toggle and last-packet bits on the next cycle.
- R4: With two copies held, the word shows the front copy, including the count latched at its event. For a zero-length packet followed by a SETUP packet with data, this means last=1 and count=0.
- R5: A read in `ST_TWO` advances the word to the back copy on the next cycle, so the second read returns the SETUP packet's status.
- R6: After reset every status bit is 0, the state is `ST_EMPTY` and the overflow flag is 0.
- R7: A read in `ST_EMPTY` changes nothing.
- R8: An event in `ST_TWO` with no read overwrites the back copy and sets the sticky overflow flag. The front copy is kept.
- R9: A read and an event in the same cycle first retire the front copy and then store the new status behind any remaining copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_end | input | 1 | One-cycle packet-end event |
| pkt_setup | input | 1 | SETUP flag of the finished packet |
| pkt_toggle | input | 1 | Data toggle of the finished packet |
| pkt_last | input | 1 | Last-packet flag of the finished packet |
| fifo_level | input | 4 | Live receive FIFO fill level |
| rd_stb | input | 1 | Firmware read strobe, consumes the current word |
| stat_word | output | 8 | Status word seen by firmware |
| ovf_seen | output | 1 | Sticky overflow flag, set on a third pending event |

## Verification
The bench builds the block with its default count width of 4 bits and a saturation limit of 8. This lets the random FIFO levels from 9 to 15 reach the clamp, while zero-length events reach the latched zero count. Random mixes of events and reads cover every state pair. These mixes include simultaneous read and event in all three states and repeated overflow in `ST_TWO`. Directed sequences add the zero-length-then-SETUP ordering and reads of an empty register.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
    localparam int CNT_W = 4;

    typedef struct packed {
        logic             setup;
        logic             toggle;
        logic             last;
        logic [CNT_W-1:0] count;
    } rx_stat_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2
    } hold_state_t;
endpackage

// File: rtl/rx_stat_slot.sv
module rx_stat_slot
    import rx_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  rx_stat_t din,
    output rx_stat_t dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/rx_stat_ctrl.sv
module rx_stat_ctrl
    import rx_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev,
    input  logic        rd,
    output hold_state_t state,
    output logic        ld_front,
    output logic        ld_back,
    output logic        shift,
    output logic        ovf
);
    hold_state_t nxt;
    logic        ovf_set;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            ovf   <= 1'b0;
        end else begin
            state <= nxt;
            if (ovf_set)
                ovf <= 1'b1;
        end
    end

    always_comb begin
        nxt      = state;
        ld_front = 1'b0;
        ld_back  = 1'b0;
        shift    = 1'b0;
        ovf_set  = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (ev) begin
                    ld_front = 1'b1;
                    nxt      = ST_ONE;
                end
            end
            ST_ONE: begin
                if (rd && ev) begin
                    ld_front = 1'b1;
                end else if (rd) begin
                    nxt = ST_EMPTY;
                end else if (ev) begin
                    ld_back = 1'b1;
                    nxt     = ST_TWO;
                end
            end
            ST_TWO: begin
                if (rd) begin
                    ld_front = 1'b1;
                    shift    = 1'b1;
                    if (ev)
                        ld_back = 1'b1;
                    else
                        nxt = ST_ONE;
                end else if (ev) begin
                    ld_back = 1'b1;
                    ovf_set = 1'b1;
                end
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TWO && ev && !rd) |=> (ovf && state == ST_TWO));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && rd && !ev) |=> (state == ST_EMPTY));
endmodule

// File: rtl/rx_stat_dbuf.sv
module rx_stat_dbuf
    import rx_stat_pkg::*;
#(
    parameter int MAX_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_end,
    input  logic             pkt_setup,
    input  logic             pkt_toggle,
    input  logic             pkt_last,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic             rd_stb,
    output logic [7:0]       stat_word,
    output logic             ovf_seen
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_CNT);

    hold_state_t      state;
    logic             ld_front, ld_back, shift;
    logic [CNT_W-1:0] lvl_sat;
    rx_stat_t         incoming;
    rx_stat_t         slot_din [2];
    rx_stat_t         slot_q   [2];
    logic [1:0]       slot_ld;

    assign lvl_sat  = (fifo_level > CAP) ? CAP : fifo_level;
    assign incoming = '{setup: pkt_setup, toggle: pkt_toggle,
                        last: pkt_last, count: lvl_sat};

    assign slot_din[0] = shift ? slot_q[1] : incoming;
    assign slot_din[1] = incoming;
    assign slot_ld     = {ld_back, ld_front};

    rx_stat_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (pkt_end),
        .rd       (rd_stb),
        .state    (state),
        .ld_front (ld_front),
        .ld_back  (ld_back),
        .shift    (shift),
        .ovf      (ovf_seen)
    );

    for (genvar g = 0; g < 2; g++) begin : g_slot
        rx_stat_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_ld[g]),
            .din   (slot_din[g]),
            .dout  (slot_q[g])
        );
    end

    always_comb begin
        stat_word = '0;
        unique case (state)
            ST_EMPTY: stat_word[3:0] = lvl_sat;
            ST_ONE:   stat_word = {1'b0, slot_q[0].setup, slot_q[0].toggle,
                                   slot_q[0].last, lvl_sat};
            ST_TWO:   stat_word = {1'b0, slot_q[0].setup, slot_q[0].toggle,
                                   slot_q[0].last, slot_q[0].count};
            default:  stat_word = '0;
        endcase
    end

    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[3:0] <= CAP);
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ONE && rd_stb && !pkt_end) |=> (stat_word[6:4] == 3'b000));
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TWO && rd_stb && !pkt_end) |=>
        (stat_word[6:4] == {$past(slot_q[1].setup), $past(slot_q[1].toggle),
                            $past(slot_q[1].last)}));
    p_front_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TWO && pkt_end && !rd_stb) |=> $stable(stat_word));
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && pkt_end) |=>
        (stat_word[6:4] == {$past(pkt_setup), $past(pkt_toggle), $past(pkt_last)}));
endmodule

// File: tb/tb_rx_stat_dbuf.sv
module tb_rx_stat_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_end = 1'b0, pkt_setup = 1'b0, pkt_toggle = 1'b0, pkt_last = 1'b0;
    logic [3:0] fifo_level = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] stat_word;
    logic       ovf_seen;

    int n_run = 0;
    int n_fail = 0;

    logic [6:0] mq0 = '0, mq1 = '0;
    int         mn = 0;
    logic       movf = 1'b0;

    always #5 clk = ~clk;

    rx_stat_dbuf dut (
        .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .pkt_setup(pkt_setup),
        .pkt_toggle(pkt_toggle), .pkt_last(pkt_last), .fifo_level(fifo_level),
        .rd_stb(rd_stb), .stat_word(stat_word), .ovf_seen(ovf_seen)
    );

    function automatic logic [3:0] sat(input logic [3:0] v);
        return (v > 4'd8) ? 4'd8 : v;
    endfunction

    function automatic logic [7:0] exp_word(input logic [3:0] live);
        if (mn == 0) return {4'b0000, sat(live)};
        if (mn == 1) return {1'b0, mq0[6:4], sat(live)};
        return {1'b0, mq0};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic s, input logic t, input logic l,
                        input logic [3:0] lvl, input logic rd, input string tag);
        logic [6:0] ent;
        @(negedge clk);
        pkt_end = ev; pkt_setup = s; pkt_toggle = t; pkt_last = l;
        fifo_level = lvl; rd_stb = rd;
        #1;
        check(tag, stat_word, exp_word(lvl));
        check({tag, " ovf R8"}, {7'd0, ovf_seen}, {7'd0, movf});
        @(posedge clk);
        ent = {s, t, l, sat(lvl)};
        if (rd && mn > 0) begin
            mq0 = mq1;
            mn  = mn - 1;
        end
        if (ev) begin
            if (mn == 0) begin mq0 = ent; mn = 1; end
            else if (mn == 1) begin mq1 = ent; mn = 2; end
            else begin mq1 = ent; movf = 1'b1; end
        end
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R6: reset state
        check("R6 reset word", stat_word, 8'h00);
        check("R6 reset ovf", {7'd0, ovf_seen}, 8'h00);

        // R7: read of empty register
        step(0, 0, 0, 0, 4'd0, 1, "R7 empty read");
        step(0, 0, 0, 0, 4'd3, 0, "R7 after empty read, R2 live");

        // R4/R5: zero-length then SETUP with data
        step(1, 0, 1, 1, 4'd0, 0, "R4 zero-length event");
        step(1, 1, 0, 0, 4'd8, 0, "R4 setup event");
        step(0, 0, 0, 0, 4'd8, 1, "R4 first read shows zero-length");
        step(0, 0, 0, 0, 4'd8, 1, "R5 second read shows SETUP");
        step(0, 0, 0, 0, 4'd8, 0, "R3 flags cleared after read");
        step(0, 0, 0, 0, 4'd13, 0, "R2 saturation at 8");

        // R8: overflow on third event
        step(1, 1, 1, 1, 4'd2, 0, "R8 fill front");
        step(1, 0, 1, 0, 4'd4, 0, "R8 fill back");
        step(1, 1, 0, 1, 4'd6, 0, "R8 third event");
        step(0, 0, 0, 0, 4'd6, 1, "R8 front kept");
        step(0, 0, 0, 0, 4'd6, 1, "R8 back overwritten");

        // R9: simultaneous read and event
        step(1, 0, 0, 1, 4'd1, 0, "R9 load");
        step(1, 1, 1, 0, 4'd5, 1, "R9 read+event in ONE");
        step(1, 0, 1, 1, 4'd0, 0, "R9 second copy");
        step(1, 1, 0, 0, 4'd7, 1, "R9 read+event in TWO");
        step(0, 0, 0, 0, 4'd7, 1, "R9 drain");
        step(0, 0, 0, 0, 4'd7, 1, "R9 drain last");
        step(0, 0, 0, 0, 4'd7, 0, "R1 layout empty");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 4'($urandom % 16), ($urandom % 3) == 0, "R1 R3 R9 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule